// File: doc/BRIEF.md
# Interlaced Field Capture Controller

This block holds the control and interrupt state for capturing interlaced video into memory, with even and odd fields handled on their own. A capture register arms each field for continuous capture or for a single capture that disarms itself. The same register holds per-field done, FIFO-corrupt and address-error flags, together with a FIFO enable, a video reset control, a corruption-detect disable and an address-range-check enable. An interrupt register holds three status bits (end of even field, end of odd field, start of field) and an enable for each. The single interrupt line is the OR of the enabled status bits.

Software writes either register through a one-cycle write strobe, with a select between the two. Both registers can be read back at all times on dedicated outputs. The video front end supplies field-start and field-end strobes, a parity level, and one-cycle FIFO-overflow and DMA-address-error pulses. A pulse is charged to the field named by the parity level in the same cycle. The pixel datapath and the bus master are outside this block.

Top module: `field_capture_ctrl`

## Requirements
- R1: After reset the capture register reads 0x00C0 (video reset control and FIFO enable set) and the interrupt register reads 0x0307. Because of that value, `irq_o` is high straight after reset.
- R2: A write to the capture register (`reg_sel_i`=0) loads bits 0,1 (continuous even/odd), 2,3 (single even/odd), 6 (video reset), 7 (FIFO enable), 14 (corruption-detect disable) and 15 (range-check enable) from the written data. Bits 12 and 13 always read 0.
- R3: On a field-end strobe with parity p (`fld_odd_i` 0 = even, 1 = odd), the field is enabled if bit p or bit 2+p is set. An enabled field sets done bit 4+p and interrupt status bit p. A field-end strobe for a field that is not enabled changes nothing.
- R4: Single bit 2+p clears itself at the end of field p. Continuous bits stay set. If a capture-register write lands in the same cycle, the written value of the single bit wins.
- R5: A FIFO-overflow pulse sets corrupt bit 8+p only when bit 7 is 1 and bit 14 is 0. Otherwise the pulse is ignored.
- R6: A DMA-address-error pulse sets bit 10+p only when bit 15 is 1. Otherwise the pulse is ignored.
- R7: Writing 1 to capture bits 4,5,8,9,10,11 clears them, and writing 0 leaves them unchanged. An event that sets a flag in the same cycle as its clear wins, so the flag ends set.
- R8: A field-start strobe sets interrupt status bit 2, whatever the capture state.
- R9: A write to the interrupt register (`reg_sel_i`=1) clears status bits 0..2 where the data has 1s, with a same-cycle event winning. It loads enables 8..10 from the data. All other bits read 0.
- R10: `irq_o` is high exactly when some interrupt status bit and its enable are both set in the registered state. It therefore rises in the cycle after the event that sets the status bit.
- R11: Writing 0x0FF3 to the capture register starts continuous capture of both fields and clears every pending flag in one write. Writing 0x0FF0 stops both fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | 0 = capture register, 1 = interrupt register |
| wr_data_i | input | 16 | Write data |
| fld_start_i | input | 1 | Start-of-field strobe |
| fld_end_i | input | 1 | End-of-field strobe |
| fld_odd_i | input | 1 | Parity of the current field (1 = odd) |
| fifo_ovf_i | input | 1 | FIFO overflow pulse |
| dma_err_i | input | 1 | DMA address error pulse |
| cap_reg_o | output | 16 | Capture register read-back |
| irq_reg_o | output | 16 | Interrupt register read-back |
| irq_o | output | 1 | Interrupt request |

## Verification
Two events can fall in the same cycle: a software write that clears or rearms a bit, and a hardware event that sets or self-clears that same bit. An example is a write-one-to-clear of a done flag while that field's end strobe arrives, or a rearm of the single bit on the same edge that disarms it. Directed cycles place the write strobe and the field strobes on one edge. A long random phase then overlaps writes with every kind of event. Each cycle is judged against a behavioural model that applies the write first and the event last, so events win over clears and writes win over self-clear.

// File: rtl/fcc_pkg.sv
package fcc_pkg;
    parameter int REG_W = 16;
    parameter int NFLD  = 2;

    // capture register layout (software decodes these positions)
    localparam int CONT_LSB   = 0;
    localparam int SINGLE_LSB = 2;
    localparam int DONE_LSB   = 4;
    localparam int VRST_BIT   = 6;
    localparam int FIFOEN_BIT = 7;
    localparam int CORR_LSB   = 8;
    localparam int ADRERR_LSB = 10;
    localparam int CDIS_BIT   = 14;
    localparam int RANGE_BIT  = 15;

    // interrupt register layout
    localparam int NIRQ       = 3;
    localparam int IEN_LSB    = 8;

    typedef struct packed {
        logic [NFLD-1:0] cont;
        logic [NFLD-1:0] single;
        logic [NFLD-1:0] done;
        logic [NFLD-1:0] corrupt;
        logic [NFLD-1:0] adr_err;
        logic            vrst;
        logic            fifo_en;
        logic            corr_dis;
        logic            range_en;
    } cap_state_t;

    typedef struct packed {
        logic [NIRQ-1:0] stat;
        logic [NIRQ-1:0] en;
    } irq_state_t;
endpackage

// File: rtl/fcc_capture_regs.sv
module fcc_capture_regs
    import fcc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [REG_W-1:0] wr_data_i,
    input  logic             fld_end_i,
    input  logic             fld_odd_i,
    input  logic             fifo_ovf_i,
    input  logic             dma_err_i,
    output logic [NFLD-1:0]  end_evt_o,
    output logic [REG_W-1:0] rd_o
);
    cap_state_t      st_d, st_q;
    logic [NFLD-1:0] par_hot;
    logic [NFLD-1:0] end_evt, ovf_evt, adr_evt;

    always_comb begin
        par_hot = fld_odd_i ? 2'b10 : 2'b01;
        for (int f = 0; f < NFLD; f++) begin
            end_evt[f] = fld_end_i & par_hot[f] & (st_q.cont[f] | st_q.single[f]);
            ovf_evt[f] = fifo_ovf_i & par_hot[f] & st_q.fifo_en & ~st_q.corr_dis;
            adr_evt[f] = dma_err_i & par_hot[f] & st_q.range_en;
        end

        st_d = st_q;
        if (wr_en_i) begin
            st_d.cont     = wr_data_i[CONT_LSB +: NFLD];
            st_d.single   = wr_data_i[SINGLE_LSB +: NFLD];
            st_d.vrst     = wr_data_i[VRST_BIT];
            st_d.fifo_en  = wr_data_i[FIFOEN_BIT];
            st_d.corr_dis = wr_data_i[CDIS_BIT];
            st_d.range_en = wr_data_i[RANGE_BIT];
            st_d.done     = st_q.done    & ~wr_data_i[DONE_LSB +: NFLD];
            st_d.corrupt  = st_q.corrupt & ~wr_data_i[CORR_LSB +: NFLD];
            st_d.adr_err  = st_q.adr_err & ~wr_data_i[ADRERR_LSB +: NFLD];
        end else begin
            st_d.single   = st_q.single & ~end_evt;
        end
        // hardware events are applied last so they win over clears
        st_d.done    = st_d.done    | end_evt;
        st_d.corrupt = st_d.corrupt | ovf_evt;
        st_d.adr_err = st_d.adr_err | adr_evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.vrst    <= 1'b1;
            st_q.fifo_en <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign end_evt_o = end_evt;
    assign rd_o = {st_q.range_en, st_q.corr_dis, 2'b00, st_q.adr_err, st_q.corrupt,
                   st_q.fifo_en, st_q.vrst, st_q.done, st_q.single, st_q.cont};

    // R4: a single even capture disarms at its field end when no write interferes
    a_r4_single_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (fld_end_i && !fld_odd_i && st_q.single[0] && !wr_en_i) |=> !st_q.single[0]);

    // R3: an odd field end with continuous odd capture marks the odd field done
    a_r3_odd_done: assert property (@(posedge clk) disable iff (!rst_n)
        (fld_end_i && fld_odd_i && st_q.cont[1]) |=> st_q.done[1]);

    // R5: corruption flags are frozen while detection is disabled and no write occurs
    a_r5_corrupt_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.corr_dis && !wr_en_i) |=> $stable(st_q.corrupt));

    // R7: the field end wins over a same-cycle clear of the even done flag
    a_r7_event_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_data_i[DONE_LSB] && fld_end_i && !fld_odd_i && st_q.cont[0])
        |=> st_q.done[0]);
endmodule

// File: rtl/fcc_irq_regs.sv
module fcc_irq_regs
    import fcc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [REG_W-1:0] wr_data_i,
    input  logic [NFLD-1:0]  end_evt_i,
    input  logic             fld_start_i,
    output logic [REG_W-1:0] rd_o,
    output logic             irq_o
);
    irq_state_t      st_d, st_q;
    logic [NIRQ-1:0] set_evt;

    always_comb begin
        set_evt = {fld_start_i, end_evt_i};
        st_d    = st_q;
        if (wr_en_i) begin
            st_d.stat = st_q.stat & ~wr_data_i[NIRQ-1:0];
            st_d.en   = wr_data_i[IEN_LSB +: NIRQ];
        end
        st_d.stat = st_d.stat | set_evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.stat <= 3'b111;
            st_q.en   <= 3'b011;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_o = |(st_q.stat & st_q.en);
    assign rd_o  = {{(REG_W-IEN_LSB-NIRQ){1'b0}}, st_q.en, {(IEN_LSB-NIRQ){1'b0}}, st_q.stat};

    // R8: a field start always leaves the start-of-field status set
    a_r8_start_sets: assert property (@(posedge clk) disable iff (!rst_n)
        fld_start_i |=> st_q.stat[2]);

    // R9: writing 1 clears the even-end status when no even end arrives
    a_r9_w1c_status: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_data_i[0] && !end_evt_i[0]) |=> !st_q.stat[0]);
endmodule

// File: rtl/field_capture_ctrl.sv
module field_capture_ctrl
    import fcc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic             reg_sel_i,
    input  logic [REG_W-1:0] wr_data_i,
    input  logic             fld_start_i,
    input  logic             fld_end_i,
    input  logic             fld_odd_i,
    input  logic             fifo_ovf_i,
    input  logic             dma_err_i,
    output logic [REG_W-1:0] cap_reg_o,
    output logic [REG_W-1:0] irq_reg_o,
    output logic             irq_o
);
    logic [NFLD-1:0] end_evt;
    logic            cap_wr, irq_wr;

    assign cap_wr = wr_en_i & ~reg_sel_i;
    assign irq_wr = wr_en_i &  reg_sel_i;

    fcc_capture_regs u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (cap_wr),
        .wr_data_i  (wr_data_i),
        .fld_end_i  (fld_end_i),
        .fld_odd_i  (fld_odd_i),
        .fifo_ovf_i (fifo_ovf_i),
        .dma_err_i  (dma_err_i),
        .end_evt_o  (end_evt),
        .rd_o       (cap_reg_o)
    );

    fcc_irq_regs u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (irq_wr),
        .wr_data_i   (wr_data_i),
        .end_evt_i   (end_evt),
        .fld_start_i (fld_start_i),
        .rd_o        (irq_reg_o),
        .irq_o       (irq_o)
    );

    // R10: an enabled end-of-even status drives the interrupt line
    a_r10_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_reg_o[0] && irq_reg_o[8]) |-> irq_o);
endmodule

// File: tb/field_capture_ctrl_tb_top.sv
module field_capture_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, reg_sel = 1'b0;
    logic [15:0] wr_data = '0;
    logic        fstart = 1'b0, fend = 1'b0, fodd = 1'b0, ovf = 1'b0, derr = 1'b0;
    logic [15:0] cap_reg, irq_reg;
    logic        irq;

    logic [15:0] m_cap, m_irq;
    int          vectors = 0, errors = 0;
    bit          chk_on = 1'b0, finished = 1'b0;
    string       cur_req = "R1";

    always #5 clk = ~clk;

    field_capture_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .reg_sel_i(reg_sel), .wr_data_i(wr_data),
        .fld_start_i(fstart), .fld_end_i(fend), .fld_odd_i(fodd), .fifo_ovf_i(ovf),
        .dma_err_i(derr), .cap_reg_o(cap_reg), .irq_reg_o(irq_reg), .irq_o(irq)
    );

    // behavioural reference: writes first, hardware events last
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cap = 16'h00C0;
            m_irq = 16'h0307;
        end else begin
            logic [15:0] nc, ni;
            int p;
            bit armed;
            p = fodd ? 1 : 0;
            armed = m_cap[p] || m_cap[2+p];
            nc = m_cap;
            ni = m_irq;
            if (wr_en && !reg_sel) begin
                nc = (nc & ~16'hC0CF) | (wr_data & 16'hC0CF);
                nc = nc & ~(wr_data & 16'h0F30);
            end
            if (wr_en && reg_sel) begin
                ni = (ni & ~16'h0700) | (wr_data & 16'h0700);
                ni = ni & ~(wr_data & 16'h0007);
            end
            if (fend && armed) begin
                nc[4+p] = 1'b1;
                if (!(wr_en && !reg_sel)) nc[2+p] = 1'b0;
                ni[p] = 1'b1;
            end
            if (ovf && m_cap[7] && !m_cap[14]) nc[8+p] = 1'b1;
            if (derr && m_cap[15]) nc[10+p] = 1'b1;
            if (fstart) ni[2] = 1'b1;
            m_cap = nc;
            m_irq = ni;
        end
        chk_on = 1'b1;
    end

    always @(negedge clk) begin
        if (chk_on && !finished) begin
            logic exp_irq;
            exp_irq = |(m_irq[2:0] & m_irq[10:8]);
            vectors++;
            if (cap_reg !== m_cap) begin
                errors++;
                $display("FAIL %s cap_reg act=%h exp=%h t=%0t", cur_req, cap_reg, m_cap, $time);
            end
            if (irq_reg !== m_irq) begin
                errors++;
                $display("FAIL %s irq_reg act=%h exp=%h t=%0t", cur_req, irq_reg, m_irq, $time);
            end
            if (irq !== exp_irq) begin
                errors++;
                $display("FAIL %s irq_o act=%b exp=%b t=%0t", cur_req, irq, exp_irq, $time);
            end
        end
    end

    task automatic cyc(input bit w, input bit s, input logic [15:0] d,
                       input bit st, input bit en, input bit od, input bit ov, input bit de);
        @(negedge clk);
        #1;
        wr_en = w; reg_sel = s; wr_data = d;
        fstart = st; fend = en; fodd = od; ovf = ov; derr = de;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 16'h0, 0, 0, 0, 0, 0);
    endtask

    task automatic wcap(input logic [15:0] d); cyc(1, 0, d, 0, 0, 0, 0, 0); endtask
    task automatic wirq(input logic [15:0] d); cyc(1, 1, d, 0, 0, 0, 0, 0); endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired act=running exp=finished");
            finished = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset values and interrupt line after reset
        cur_req = "R1";
        repeat (3) @(posedge clk);
        @(negedge clk); #1; rst_n = 1'b1;
        idle(3);
        // R2: control bits load, bits 12 and 13 read zero
        cur_req = "R2";
        wcap(16'hFFFF); idle(1);
        wcap(16'h3000); idle(1);
        wcap(16'h80C0); idle(1);
        // R3: armed field end sets done and status; unarmed field ignored
        cur_req = "R3";
        wirq(16'h0007); wcap(16'h00C1);
        cyc(0, 0, 0, 0, 1, 1, 0, 0); idle(1);
        cyc(0, 0, 0, 0, 1, 0, 0, 0); idle(1);
        wcap(16'h00F2);
        cyc(0, 0, 0, 0, 1, 1, 0, 0); idle(1);
        // R4: single bit disarms; rearm in the same cycle wins
        cur_req = "R4";
        wcap(16'h00F8);
        cyc(0, 0, 0, 0, 1, 1, 0, 0);
        cyc(0, 0, 0, 0, 1, 1, 0, 0); idle(1);
        wcap(16'h00C4);
        cyc(1, 0, 16'h00C4, 0, 1, 0, 0, 0); idle(1);
        cyc(0, 0, 0, 0, 1, 0, 0, 0); idle(1);
        // R5: FIFO overflow gated by FIFO enable and detect disable
        cur_req = "R5";
        wcap(16'h0FC0);
        cyc(0, 0, 0, 0, 0, 0, 1, 0); cyc(0, 0, 0, 0, 0, 1, 1, 0);
        wcap(16'h4F40);
        cyc(0, 0, 0, 0, 0, 0, 1, 0);
        wcap(16'h0F40);
        cyc(0, 0, 0, 0, 0, 1, 1, 0); idle(1);
        // R6: address error gated by range check enable
        cur_req = "R6";
        wcap(16'h0FC0);
        cyc(0, 0, 0, 0, 0, 1, 0, 1);
        wcap(16'h80C0);
        cyc(0, 0, 0, 0, 0, 1, 0, 1); cyc(0, 0, 0, 0, 0, 0, 0, 1); idle(1);
        // R7: write-one clears, zero keeps, event beats clear
        cur_req = "R7";
        wcap(16'h80C3);
        cyc(0, 0, 0, 0, 1, 0, 1, 0);
        cyc(1, 0, 16'h84C3, 0, 0, 0, 0, 0);
        cyc(1, 0, 16'h80D3, 0, 1, 0, 0, 0);
        cyc(1, 0, 16'h8FF3, 0, 0, 1, 1, 1); idle(1);
        // R8: start of field status
        cur_req = "R8";
        wirq(16'h0007);
        cyc(0, 0, 0, 1, 0, 0, 0, 0);
        cyc(1, 1, 16'h0004, 1, 0, 0, 0, 0); idle(1);
        // R9: status clears and enable loads
        cur_req = "R9";
        wirq(16'hFFFF); wirq(16'h0400);
        cyc(1, 1, 16'h0001, 0, 1, 0, 0, 0); idle(1);
        // R10: interrupt line against masked and unmasked status
        cur_req = "R10";
        wirq(16'h0007); wcap(16'h00C3);
        cyc(0, 0, 0, 0, 1, 1, 0, 0); wirq(16'h0200); wirq(16'h0002); idle(1);
        // R11: start both fields and clear flags, then stop
        cur_req = "R11";
        wcap(16'h00C0);
        cyc(0, 0, 0, 0, 0, 0, 1, 0);
        wcap(16'h0FF3);
        cyc(0, 0, 0, 0, 1, 0, 0, 0); cyc(0, 0, 0, 0, 1, 1, 0, 0);
        wcap(16'h0FF0);
        cyc(0, 0, 0, 0, 1, 0, 0, 0); idle(1);
        // R7/R4 overlap: random writes racing with field events
        cur_req = "R7";
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] d;
            d = 16'($urandom);
            cyc(($urandom % 4) == 0, $urandom % 2, d, ($urandom % 5) == 0,
                ($urandom % 3) == 0, $urandom % 2, ($urandom % 4) == 0, ($urandom % 4) == 0);
        end
        idle(2);
        finished = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule